// File: doc/BRIEF.md
# Synchronized PWM Bank with Atomic Reload

This block drives a bank of complementary PWM output pairs from one shared up/down (center-aligned) counter. It holds one period value for the shared counter. Each channel holds a compare value and a dead-time value. Every one of these settings exists twice: a staged copy that software writes at any time, and a live copy that the waveform logic uses. Writes never touch the live copies directly.

Software stages a full new set of values through a single write port and then pulses one global load command. The block arms a reload and shows a pending flag. At the next selected counter turnaround (bottom, top, or either), every channel and the period copy staged values to live values in the same clock. A set of writes that straddles a turnaround therefore cannot leave some channels on the old values and others on the new ones.

An interrupt pulse marks bottom turnarounds and can be thinned to every Nth PWM cycle.

Top module: `pwm_bank_sync`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs (`out_a`, `out_b`, `irq`, `load_pending`) go low and all staged and live settings become zero.
- R2: The counter starts at 0 counting up, rises to the live period P, then falls to 0, giving a PWM cycle of 2P clocks (with P = 0 it stays at 0). A top event occurs when counting up at a value >= P. A bottom event occurs when counting down at 0.
- R3: Writes change only the staged copies. With no armed load, the outputs keep following the live values.
- R4: A one-cycle `load_req` pulse sets `load_pending` on the next clock. The flag clears itself on the clock after the reload it armed is applied.
- R5: `reload_sel` picks the reload events: bit 0 selects bottom events and bit 1 selects top events. With value 0 no reload happens and the load stays pending.
- R6: If `load_req` arrives in the same clock as a selected event, that event does not apply it. The reload is applied at the following selected event.
- R7: A reload copies the period and every channel's compare and dead-time values in the same clock. The new values take effect from the next clock.
- R8: At reload, a staged compare larger than the staged period is loaded as the period.
- R9: Write addresses: 0 is the period, 1..N are channel compares, N+1..2N are channel dead times (low bits). Other addresses change nothing.
- R10: The raw level of a channel is high while counter < live compare. `out_a` is high in a clock only if the raw level was high in each of the previous D+1 clocks. `out_b` is high only if it was low in each of those clocks. D is the live dead time. The two outputs are never high together.
- R11: `irq` pulses for one clock after a bottom event, on every (`irq_div`+1)th bottom event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for staged settings |
| wr_addr | input | AW | Setting select (see R9) |
| wr_data | input | CW | Write value |
| load_req | input | 1 | Global load command |
| reload_sel | input | 2 | Reload event select: bit 0 bottom, bit 1 top |
| irq_div | input | DIVW | Interrupt thinning: fire every irq_div+1 PWM cycles |
| out_a | output | NCH | Primary PWM outputs |
| out_b | output | NCH | Complementary PWM outputs |
| irq | output | 1 | Bottom-event interrupt pulse |
| load_pending | output | 1 | Reload armed and not yet applied |

## Verification
The properties assume that reset is held for at least two clocks at the start and that all inputs change only between clock edges. They also assume `load_req` is a single-clock command, so a rising pending flag can always be traced to the command before it. The stimulus holds reset for three clocks and drives every input just after the falling edge. It finds the cycle of a selected event by running its own counter model, and it presses the load command there to exercise the deferral rule.

// File: rtl/pwm_bank_sync.sv
module pwm_bank_sync #(
  parameter int NCH  = 8,
  parameter int CW   = 16,
  parameter int DBW  = 8,
  parameter int DIVW = 4,
  localparam int AW  = $clog2(2*NCH+1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic            load_req,
  input  logic [1:0]      reload_sel,
  input  logic [DIVW-1:0] irq_div,
  output logic [NCH-1:0]  out_a,
  output logic [NCH-1:0]  out_b,
  output logic            irq,
  output logic            load_pending
);

  logic [CW-1:0]   prd_sh, prd_act, cnt;
  logic            up, armed;
  logic [DIVW-1:0] irq_cnt;

  wire zero_ev = !up && (cnt == '0);
  wire prd_ev  = up && (cnt >= prd_act);
  wire bnd     = (reload_sel[0] && zero_ev) || (reload_sel[1] && prd_ev);
  wire apply   = armed && bnd;

  assign load_pending = armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      up      <= 1'b1;
      prd_sh  <= '0;
      prd_act <= '0;
      armed   <= 1'b0;
      irq_cnt <= '0;
      irq     <= 1'b0;
    end else begin
      if (up) begin
        if (cnt >= prd_act) begin
          up  <= 1'b0;
          cnt <= (cnt == '0) ? '0 : cnt - CW'(1);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        if (cnt == '0) begin
          up  <= 1'b1;
          cnt <= (prd_act == '0) ? '0 : CW'(1);
        end else begin
          cnt <= cnt - CW'(1);
        end
      end

      if (load_req)   armed <= 1'b1;
      else if (apply) armed <= 1'b0;

      if (apply) prd_act <= prd_sh;
      if (wr_en && wr_addr == '0) prd_sh <= wr_data;

      irq <= zero_ev && (irq_cnt >= irq_div);
      if (zero_ev) irq_cnt <= (irq_cnt >= irq_div) ? '0 : irq_cnt + DIVW'(1);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0]  cmp_sh, cmp_act;
    logic [DBW-1:0] db_sh, db_act, run, run_n;
    logic           lvl, raw, a_q, b_q;

    assign raw   = cnt < cmp_act;
    assign run_n = (raw != lvl) ? '0 : ((&run) ? run : run + DBW'(1));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_sh  <= '0;
        cmp_act <= '0;
        db_sh   <= '0;
        db_act  <= '0;
        run     <= '0;
        lvl     <= 1'b0;
        a_q     <= 1'b0;
        b_q     <= 1'b0;
      end else begin
        if (apply) begin
          cmp_act <= (cmp_sh > prd_sh) ? prd_sh : cmp_sh;
          db_act  <= db_sh;
        end
        if (wr_en && wr_addr == AW'(i + 1))       cmp_sh <= wr_data;
        if (wr_en && wr_addr == AW'(NCH + 1 + i)) db_sh  <= wr_data[DBW-1:0];
        lvl <= raw;
        run <= run_n;
        a_q <= raw && (run_n >= db_act);
        b_q <= !raw && (run_n >= db_act);
      end
    end

    assign out_a[i] = a_q;
    assign out_b[i] = b_q;
  end

endmodule

// File: rtl/pwm_bank_sync_chk.sv
module pwm_bank_sync_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           load_req,
  input logic           load_pending,
  input logic           zero_ev,
  input logic           bnd,
  input logic           apply,
  input logic [CW-1:0]  prd_act,
  input logic [NCH-1:0] out_a,
  input logic [NCH-1:0] out_b,
  input logic           irq
);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    (out_a & out_b) == '0);

  assert_pending_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(load_pending) |-> $past(load_req));

  assert_pending_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(load_pending) |-> $past(bnd));

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(apply) |-> $stable(prd_act));

  assert_defer_R6: assert property (@(posedge clk) disable iff (rst)
    (load_req && bnd && !load_pending) |=> load_pending);

  assert_irq_bottom_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(zero_ev));

endmodule

bind pwm_bank_sync pwm_bank_sync_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .load_req(load_req), .load_pending(load_pending),
  .zero_ev(zero_ev), .bnd(bnd), .apply(apply), .prd_act(prd_act),
  .out_a(out_a), .out_b(out_b), .irq(irq)
);

// File: tb/sim_pwm_bank_sync.sv
module sim_pwm_bank_sync;
  localparam int NCH = 4, CW = 8, DBW = 4, DIVW = 3;
  localparam int AW = $clog2(2*NCH+1);

  logic clk = 1'b0;
  logic rst, wr_en, load_req, irq, load_pending;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic [1:0] reload_sel;
  logic [DIVW-1:0] irq_div;
  logic [NCH-1:0] out_a, out_b;

  always #10 clk = ~clk;

  pwm_bank_sync #(.NCH(NCH), .CW(CW), .DBW(DBW), .DIVW(DIVW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_req(load_req), .reload_sel(reload_sel), .irq_div(irq_div),
    .out_a(out_a), .out_b(out_b), .irq(irq), .load_pending(load_pending));

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R2";

  int m_cnt, m_prd, sh_prd, m_irqc;
  bit m_up, m_armed;
  int m_cmp[NCH], sh_cmp[NCH], m_db[NCH], sh_db[NCH];
  logic [15:0] m_hist[NCH];
  logic [NCH-1:0] e_a, e_b;
  logic e_irq, e_pend;

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit bnd_now();
    return (reload_sel[0] && !m_up && m_cnt == 0) || (reload_sel[1] && m_up && m_cnt >= m_prd);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_prd = 0; sh_prd = 0; m_irqc = 0; m_armed = 0;
    for (int i = 0; i < NCH; i++) begin
      m_cmp[i] = 0; sh_cmp[i] = 0; m_db[i] = 0; sh_db[i] = 0; m_hist[i] = '0;
    end
  endtask

  task automatic model_step(input bit ld, input bit we, input int a, input int d);
    bit zero, top, apply;
    logic [16:0] mask;
    zero  = !m_up && m_cnt == 0;
    top   = m_up && m_cnt >= m_prd;
    apply = m_armed && ((reload_sel[0] && zero) || (reload_sel[1] && top));
    for (int i = 0; i < NCH; i++) begin
      m_hist[i] = {m_hist[i][14:0], (m_cnt < m_cmp[i])};
      mask = (17'd1 << (m_db[i] + 1)) - 17'd1;
      e_a[i] = ((17'(m_hist[i]) & mask) == mask);
      e_b[i] = ((17'(m_hist[i]) & mask) == 17'd0);
    end
    e_irq = zero && (m_irqc >= int'(irq_div));
    if (zero) m_irqc = (m_irqc >= int'(irq_div)) ? 0 : m_irqc + 1;
    if (m_up) begin
      if (m_cnt >= m_prd) begin m_up = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
      else m_cnt = m_cnt + 1;
    end else begin
      if (m_cnt == 0) begin m_up = 1; m_cnt = (m_prd == 0) ? 0 : 1; end
      else m_cnt = m_cnt - 1;
    end
    if (ld) m_armed = 1; else if (apply) m_armed = 0;
    e_pend = m_armed;
    if (apply) begin
      m_prd = sh_prd;
      for (int i = 0; i < NCH; i++) begin
        m_cmp[i] = (sh_cmp[i] > sh_prd) ? sh_prd : sh_cmp[i];
        m_db[i]  = sh_db[i];
      end
    end
    if (we) begin
      if (a == 0) sh_prd = d;
      for (int i = 0; i < NCH; i++) begin
        if (a == i + 1) sh_cmp[i] = d;
        if (a == NCH + 1 + i) sh_db[i] = d % (1 << DBW);
      end
    end
  endtask

  task automatic tick(input bit ld, input bit we, input int a, input int d);
    load_req = ld; wr_en = we; wr_addr = AW'(a); wr_data = CW'(d);
    model_step(ld, we, a, d);
    @(posedge clk); @(negedge clk);
    load_req = 0; wr_en = 0;
    check(out_a == e_a, {tag, " out_a"}, int'(out_a), int'(e_a));
    check(out_b == e_b, {tag, " out_b"}, int'(out_b), int'(e_b));
    check(irq == e_irq, {tag, " irq"}, int'(irq), int'(e_irq));
    check(load_pending == e_pend, {tag, " pending"}, int'(load_pending), int'(e_pend));
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    tick(0, 1, a, d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; load_req = 0; wr_addr = '0; wr_data = '0;
    reload_sel = 2'b01; irq_div = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check({out_a, out_b, irq, load_pending} == '0, "R1 reset outputs",
          int'({out_a, out_b, irq, load_pending}), 0);
    rst = 0;

    // R1: settings zero after reset -> counter idles, out_b high, irq every bottom
    tag = "R1"; run(6);

    // R3: stage values, no load -> outputs keep old live values
    tag = "R3";
    wr(0, 6);
    for (int i = 0; i < NCH; i++) wr(i + 1, 2 * i + 1);
    for (int i = 0; i < NCH; i++) wr(NCH + 1 + i, i);
    run(20);

    // R4/R7/R8: load at bottom, all channels switch together; ch3 compare 7 > 6 is clamped
    tag = "R4"; reload_sel = 2'b01; tick(1, 0, 0, 0);
    check(load_pending == 1'b1, "R4 pending after load", int'(load_pending), 1);
    tag = "R7"; run(40);
    check(load_pending == 1'b0, "R4 pending cleared", int'(load_pending), 0);
    tag = "R8"; wr(4, 200); tick(1, 0, 0, 0); run(30);

    // R11: interrupt thinning sweep
    tag = "R11";
    for (int dv = 0; dv < 4; dv++) begin irq_div = DIVW'(dv); run(60); end
    irq_div = '0;

    // R5: top-event reload with a new period
    tag = "R5"; reload_sel = 2'b10;
    wr(0, 4); wr(1, 3); tick(1, 0, 0, 0); run(30);
    // R5: no event selected -> stays pending
    reload_sel = 2'b00; wr(2, 1); tick(1, 0, 0, 0); run(30);
    check(load_pending == 1'b1, "R5 held pending", int'(load_pending), 1);
    reload_sel = 2'b11; run(10);

    // R6: load pressed in the same cycle as a selected event
    tag = "R6"; reload_sel = 2'b01; wr(0, 5); wr(3, 2);
    while (!bnd_now()) tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    check(load_pending == 1'b1, "R6 deferred", int'(load_pending), 1);
    run(25);

    // R9: unused addresses change nothing
    tag = "R9";
    for (int a = 2 * NCH + 1; a < (1 << AW); a++) wr(a, 8'hA5);
    tick(1, 0, 0, 0); run(25);

    // R2/R10: sweep period, compare and dead time
    tag = "R10"; reload_sel = 2'b11;
    for (int p = 0; p <= 5; p++) begin
      for (int c = 0; c <= p + 1; c++) begin
        wr(0, p);
        for (int i = 0; i < NCH; i++) begin wr(i + 1, c + i); wr(NCH + 1 + i, (c + i) % 4); end
        tick(1, 0, 0, 0);
        run(4 * p + 12);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule